// File: doc/BRIEF.md
# Split-Channel PWM Duty Decoder

The block recovers two signed measurements from a single active-low PWM line that is time-shared by a reference square wave (`sync`). Every interval in which `sync` stays high is one measurement slot for channel 1. Every interval in which `sync` stays low is a slot for channel 2. During each slot the block counts the system clocks in the slot and the clocks in which `pwm_n` is low. When `sync` toggles, the block divides the two counts into a fixed-point duty ratio. It clamps the ratio to the legal 10 %..30 % window, centres it on 20 %, scales it by ten, subtracts the channel's own signed offset and saturates the result into the output width. The result appears on that channel's value port together with a one-clock valid strobe.

The slot length comes from that slot alone, so an asymmetric `sync` does not bias either channel. Both inputs pass through two-flop synchronisers with equal delay, so the counts cover exactly the clocks of each slot. Control sits in a four-state sequencer. `TP_WAIT` goes to `TP_DIVIDE` when a slot completes. `TP_DIVIDE` goes to `TP_SCALE` when the divider finishes. `TP_SCALE` goes to `TP_EMIT` unconditionally, and `TP_EMIT` returns to `TP_WAIT`. The divider has its own three-state machine. `DV_IDLE` goes to `DV_RUN` on start. `DV_RUN` goes to `DV_DONE` after FRAC+1 steps, and `DV_DONE` returns to `DV_IDLE`. Every slot must last at least 24 clocks so that decoding ends before the next slot completes.

Top module: `pwm_duty_decoder`

## Requirements
- R1: A slot during which `sync` was high produces a result only on the channel-1 ports (`val_ch1`, `vld_ch1`, `oor_ch1`). A slot during which `sync` was low produces a result only on the channel-2 ports.
- R2: The slot in progress when reset is released is partial and produces no result. Decoding starts with the first slot that begins after the first `sync` toggle.
- R3: For a slot of T clocks with L clocks of `pwm_n` low, the ratio is q = floor(L*2^FRAC/T). With FRAC=12, q = 4096 means 100 %.
- R4: The result is (qc - 819)*10 - offset, where qc is the clamped ratio (FRAC=12). A 20 % duty with zero offset gives 0.
- R5: If q < 410 or q > 1229, `oor_chN` is 1 and qc is q clamped to that bound. Otherwise `oor_chN` is 0 and qc = q.
- R6: Channel 1 subtracts `offset_ch1` and channel 2 subtracts `offset_ch2`. The offset is read when that slot's result is computed.
- R7: Each completed slot gives exactly one valid pulse. The pulse lasts one clock, and the two valid outputs are never high together.
- R8: The result saturates to the signed OW-bit range, which is -32768..32767 for OW=16.
- R9: After reset, all valid strobes, values and out-of-range flags are 0.
- R10: Each slot's ratio uses its own length, so halves of unequal length decode independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_n | input | 1 | Active-low PWM stream |
| sync | input | 1 | Slot reference: high selects channel 1, low selects channel 2 |
| offset_ch1 | input | OW | Signed offset for channel 1 |
| offset_ch2 | input | OW | Signed offset for channel 2 |
| val_ch1 | output | OW | Signed channel-1 result |
| vld_ch1 | output | 1 | One-clock strobe for a new channel-1 result |
| oor_ch1 | output | 1 | Channel-1 duty was outside 10..30 % |
| val_ch2 | output | OW | Signed channel-2 result |
| vld_ch2 | output | 1 | One-clock strobe for a new channel-2 result |
| oor_ch2 | output | 1 | Channel-2 duty was outside 10..30 % |

## Verification
The bench targets the following corner cases and the failure each one exposes:
- **Partial first slot.** The bench supplies an incomplete slot after reset. A design that decodes it emits a result with nothing expected in the scoreboard.
- **Duty just below 10 %, at 0 % and at 100 %.** These exercise clamping and the out-of-range flag. A wrong bound or a missing clamp gives a value beyond ±4100 or a flag of 0.
- **Unequal halves.** These reveal a decoder that divides by a shared or full period, because the 20 % slots would then not decode to zero.
- **Separate offsets and extreme offsets.** Distinct offsets catch swapped channels. Extreme offsets push the sum past the output range, and a design without saturation wraps to the opposite sign.

// File: rtl/pwmdec_pkg.sv
package pwmdec_pkg;

    typedef enum logic [1:0] {
        DV_IDLE,
        DV_RUN,
        DV_DONE
    } div_state_t;

    typedef enum logic [1:0] {
        TP_WAIT,
        TP_DIVIDE,
        TP_SCALE,
        TP_EMIT
    } top_state_t;

endpackage

// File: rtl/pwmdec_meter.sv
module pwmdec_meter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwm_n_i,
    input  logic          sync_i,
    output logic          done_o,
    output logic          ch1_o,
    output logic [CW-1:0] low_o,
    output logic [CW-1:0] total_o
);

    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    logic          pwm_s1, pwm_s2;
    logic          syn_s1, syn_s2, syn_s3;
    logic          armed;
    logic [CW-1:0] tot_cnt, low_cnt;
    logic          slot_edge;
    logic [CW-1:0] low_inc;

    assign slot_edge = syn_s2 ^ syn_s3;
    assign low_inc   = {{(CW-1){1'b0}}, ~pwm_s2};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwm_s1  <= 1'b1;
            pwm_s2  <= 1'b1;
            syn_s1  <= 1'b0;
            syn_s2  <= 1'b0;
            syn_s3  <= 1'b0;
            armed   <= 1'b0;
            tot_cnt <= '0;
            low_cnt <= '0;
            done_o  <= 1'b0;
            ch1_o   <= 1'b0;
            low_o   <= '0;
            total_o <= '0;
        end else begin
            pwm_s1 <= pwm_n_i;
            pwm_s2 <= pwm_s1;
            syn_s1 <= sync_i;
            syn_s2 <= syn_s1;
            syn_s3 <= syn_s2;
            done_o <= 1'b0;
            if (slot_edge) begin
                if (armed) begin
                    done_o  <= 1'b1;
                    ch1_o   <= syn_s3;
                    low_o   <= low_cnt;
                    total_o <= tot_cnt;
                end
                armed   <= 1'b1;
                tot_cnt <= {{(CW-1){1'b0}}, 1'b1};
                low_cnt <= low_inc;
            end else if (tot_cnt != CNT_MAX) begin
                tot_cnt <= tot_cnt + 1'b1;
                low_cnt <= low_cnt + low_inc;
            end
        end
    end

    // R3: a reported slot is never empty and never has more low clocks than total clocks
    p_counts_sane_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (total_o != '0) && (low_o <= total_o));

endmodule

// File: rtl/pwmdec_divider.sv
module pwmdec_divider
    import pwmdec_pkg::*;
#(
    parameter int CW   = 16,
    parameter int FRAC = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [CW-1:0] num_i,
    input  logic [CW-1:0] den_i,
    output logic          done_o,
    output logic [FRAC:0] quo_o
);

    localparam int           STW      = $clog2(FRAC + 1) + 1;
    localparam logic [STW-1:0] LAST   = STW'(FRAC);
    localparam logic [FRAC:0]  QUO_MAX = {1'b1, {FRAC{1'b0}}};

    div_state_t     state, state_nxt;
    logic [CW:0]    rem, trial;
    logic [CW-1:0]  den_q;
    logic [STW-1:0] step;
    logic           bit_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= DV_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            DV_IDLE: if (start_i) state_nxt = DV_RUN;
            DV_RUN:  if (step == LAST) state_nxt = DV_DONE;
            DV_DONE: state_nxt = DV_IDLE;
            default: state_nxt = DV_IDLE;
        endcase
    end

    assign trial  = (step == '0) ? rem : {rem[CW-1:0], 1'b0};
    assign bit_ok = trial >= {1'b0, den_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem   <= '0;
            den_q <= '0;
            step  <= '0;
            quo_o <= '0;
        end else begin
            unique case (state)
                DV_IDLE: if (start_i) begin
                    rem   <= {1'b0, num_i};
                    den_q <= den_i;
                    step  <= '0;
                    quo_o <= '0;
                end
                DV_RUN: begin
                    rem   <= bit_ok ? (trial - {1'b0, den_q}) : trial;
                    quo_o <= {quo_o[FRAC-1:0], bit_ok};
                    step  <= step + 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign done_o = (state == DV_DONE);

    // R3: quotient never exceeds unity
    p_quo_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> quo_o <= QUO_MAX);
    // R7: a new division is only requested while idle
    p_start_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> state == DV_IDLE);

endmodule

// File: rtl/pwm_duty_decoder.sv
module pwm_duty_decoder
    import pwmdec_pkg::*;
#(
    parameter int CW   = 16,
    parameter int FRAC = 12,
    parameter int OW   = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pwm_n,
    input  logic                 sync,
    input  logic signed [OW-1:0] offset_ch1,
    input  logic signed [OW-1:0] offset_ch2,
    output logic signed [OW-1:0] val_ch1,
    output logic                 vld_ch1,
    output logic                 oor_ch1,
    output logic signed [OW-1:0] val_ch2,
    output logic                 vld_ch2,
    output logic                 oor_ch2
);

    localparam int ONE  = 2 ** FRAC;
    localparam int MID  = (2 * ONE + 5) / 10;
    localparam int LO   = (ONE + 5) / 10;
    localparam int HI   = (3 * ONE + 5) / 10;
    localparam int WW   = OW + FRAC + 6;
    localparam logic signed [WW-1:0] MID_W  = WW'(MID);
    localparam logic signed [WW-1:0] LO_W   = WW'(LO);
    localparam logic signed [WW-1:0] HI_W   = WW'(HI);
    localparam logic signed [WW-1:0] GAIN_W = WW'(10);
    localparam logic signed [WW-1:0] SMAX_W = WW'((2 ** (OW - 1)) - 1);
    localparam logic signed [WW-1:0] SMIN_W = -SMAX_W - 1;

    top_state_t     state, state_nxt;
    logic           meas_done, meas_ch1;
    logic [CW-1:0]  meas_low, meas_total;
    logic           div_start, div_done;
    logic [FRAC:0]  div_quo, quo_q;
    logic           cur_ch1;

    logic signed [WW-1:0] q_w, qc_w, off_w, raw_w, sat_w;
    logic                 oor_w;

    pwmdec_meter #(.CW(CW)) u_meter (
        .clk     (clk),
        .rst_n   (rst_n),
        .pwm_n_i (pwm_n),
        .sync_i  (sync),
        .done_o  (meas_done),
        .ch1_o   (meas_ch1),
        .low_o   (meas_low),
        .total_o (meas_total)
    );

    assign div_start = (state == TP_WAIT) && meas_done;

    pwmdec_divider #(.CW(CW), .FRAC(FRAC)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (div_start),
        .num_i   (meas_low),
        .den_i   (meas_total),
        .done_o  (div_done),
        .quo_o   (div_quo)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TP_WAIT;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            TP_WAIT:   if (meas_done) state_nxt = TP_DIVIDE;
            TP_DIVIDE: if (div_done)  state_nxt = TP_SCALE;
            TP_SCALE:  state_nxt = TP_EMIT;
            TP_EMIT:   state_nxt = TP_WAIT;
            default:   state_nxt = TP_WAIT;
        endcase
    end

    // ratio -> clamp -> centre/scale -> offset -> saturate
    always_comb begin
        q_w   = $signed({{(WW-FRAC-1){1'b0}}, quo_q});
        oor_w = (q_w < LO_W) || (q_w > HI_W);
        if (q_w < LO_W)      qc_w = LO_W;
        else if (q_w > HI_W) qc_w = HI_W;
        else                 qc_w = q_w;
        off_w = cur_ch1 ? WW'(offset_ch1) : WW'(offset_ch2);
        raw_w = (qc_w - MID_W) * GAIN_W - off_w;
        if (raw_w > SMAX_W)      sat_w = SMAX_W;
        else if (raw_w < SMIN_W) sat_w = SMIN_W;
        else                     sat_w = raw_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_ch1 <= 1'b0;
            quo_q   <= '0;
            val_ch1 <= '0;
            val_ch2 <= '0;
            oor_ch1 <= 1'b0;
            oor_ch2 <= 1'b0;
            vld_ch1 <= 1'b0;
            vld_ch2 <= 1'b0;
        end else begin
            vld_ch1 <= 1'b0;
            vld_ch2 <= 1'b0;
            unique case (state)
                TP_WAIT:   if (meas_done) cur_ch1 <= meas_ch1;
                TP_DIVIDE: if (div_done)  quo_q   <= div_quo;
                TP_SCALE: begin
                    if (cur_ch1) begin
                        val_ch1 <= sat_w[OW-1:0];
                        oor_ch1 <= oor_w;
                        vld_ch1 <= 1'b1;
                    end else begin
                        val_ch2 <= sat_w[OW-1:0];
                        oor_ch2 <= oor_w;
                        vld_ch2 <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // R7: strobes last one clock and never coincide
    p_pulse_ch1_r7: assert property (@(posedge clk) disable iff (!rst_n)
        vld_ch1 |=> !vld_ch1);
    p_pulse_ch2_r7: assert property (@(posedge clk) disable iff (!rst_n)
        vld_ch2 |=> !vld_ch2);
    p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(vld_ch1 && vld_ch2));
    // R7: every completed slot is accepted (no overrun of the sequencer)
    p_no_overrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
        meas_done |-> state == TP_WAIT);
    // R1: a channel-1 strobe only follows a slot measured while sync was high
    p_route_r1: assert property (@(posedge clk) disable iff (!rst_n)
        vld_ch1 |-> cur_ch1);

endmodule

// File: tb/sim_pwm_duty_decoder.sv
module sim_pwm_duty_decoder;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               pwm_n = 1'b1;
    logic               sync = 1'b0;
    logic signed [15:0] offset_ch1 = '0;
    logic signed [15:0] offset_ch2 = '0;
    logic signed [15:0] val_ch1, val_ch2;
    logic               vld_ch1, vld_ch2, oor_ch1, oor_ch2;

    always #2 clk = ~clk;

    pwm_duty_decoder u0 (
        .clk(clk), .rst_n(rst_n), .pwm_n(pwm_n), .sync(sync),
        .offset_ch1(offset_ch1), .offset_ch2(offset_ch2),
        .val_ch1(val_ch1), .vld_ch1(vld_ch1), .oor_ch1(oor_ch1),
        .val_ch2(val_ch2), .vld_ch2(vld_ch2), .oor_ch2(oor_ch2)
    );

    typedef struct {
        bit ch1;
        int val;
        bit oor;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 0;

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R3 R4 R5 R8 model
    task automatic push_exp(bit ch1, int tot, int low, int off);
        exp_t e;
        int q, qc, v;
        q  = (low * 4096) / tot;
        qc = (q < 410) ? 410 : ((q > 1229) ? 1229 : q);
        v  = (qc - 819) * 10 - off;
        if (v > 32767)  v = 32767;
        if (v < -32768) v = -32768;
        e.ch1 = ch1;
        e.val = v;
        e.oor = (q < 410) || (q > 1229);
        exp_q.push_back(e);
    endtask

    task automatic half(bit lvl, int tot, int low, bit push, int o1, int o2);
        if (push) push_exp(lvl, tot, low, lvl ? o1 : o2);
        for (int i = 0; i < tot; i++) begin
            sync  = lvl;
            pwm_n = (i < low) ? 1'b0 : 1'b1;
            if (i == tot - 1) begin
                offset_ch1 = 16'(o1);
                offset_ch2 = 16'(o2);
            end
            @(negedge clk);
        end
    endtask

    // scoreboard monitor
    initial begin
        bit p1, p2;
        p1 = 0;
        p2 = 0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (vld_ch1 && vld_ch2) chk(0, "R7 both strobes", 1, 0);
                if (vld_ch1 && p1) chk(0, "R7 ch1 strobe width", 2, 1);
                if (vld_ch2 && p2) chk(0, "R7 ch2 strobe width", 2, 1);
                if ((vld_ch1 && !p1) || (vld_ch2 && !p2)) begin
                    if (exp_q.size() == 0) begin
                        chk(0, "R2 unexpected result", 1, 0);
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        chk(vld_ch1 == e.ch1, "R1 channel", int'(vld_ch1), int'(e.ch1));
                        if (vld_ch1) begin
                            chk(int'(val_ch1) == e.val, "R4 ch1 value", int'(val_ch1), e.val);
                            chk(oor_ch1 == e.oor, "R5 ch1 oor", int'(oor_ch1), int'(e.oor));
                        end else begin
                            chk(int'(val_ch2) == e.val, "R4 ch2 value", int'(val_ch2), e.val);
                            chk(oor_ch2 == e.oor, "R5 ch2 oor", int'(oor_ch2), int'(e.oor));
                        end
                    end
                end
                p1 = vld_ch1;
                p2 = vld_ch2;
            end
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R9 reset state
        chk(!vld_ch1 && !vld_ch2, "R9 strobes", int'(vld_ch1 | vld_ch2), 0);
        chk(val_ch1 == 0 && val_ch2 == 0, "R9 values", int'(val_ch1 | val_ch2), 0);
        chk(!oor_ch1 && !oor_ch2, "R9 flags", int'(oor_ch1 | oor_ch2), 0);

        half(0, 40, 8, 0, 0, 0);          // R2 partial slot, no result
        half(1, 100, 20, 1, 0, 0);        // R4 20 % -> 0
        half(0, 100, 10, 1, 0, 0);        // R5 just below 10 %
        half(1, 100, 30, 1, 0, 0);        // R3 near 30 %
        half(0, 50, 5, 1, 0, 0);          // R5 below window
        half(1, 120, 24, 1, 0, 0);        // R10 long half at 20 %
        half(0, 80, 16, 1, 0, 0);         // R10 short half at 20 %
        half(1, 60, 13, 1, 0, 0);         // R3 odd ratio
        half(0, 100, 50, 1, 0, 0);        // R5 above window
        half(1, 100, 25, 1, 100, -200);   // R6 channel-1 offset
        half(0, 100, 15, 1, 100, -200);   // R6 channel-2 offset
        half(1, 100, 30, 1, -32768, 32767); // R8 positive saturation
        half(0, 100, 10, 1, -32768, 32767); // R8 negative saturation
        half(1, 40, 0, 1, 0, 0);          // R5 0 % duty
        half(0, 40, 40, 1, 0, 0);         // R5 100 % duty
        half(1, 40, 10, 1, 0, 0);         // R3 25 %
        half(0, 40, 20, 0, 0, 0);         // trailing slot closes the last one
        repeat (60) @(negedge clk);
        // R7 every completed slot produced one result
        chk(exp_q.size() == 0, "R7 missing results", exp_q.size(), 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule